// File: doc/BRIEF.md
# Video Pattern and Component Delay Stage

This block sits in the pixel path of a component video encoder, ahead of the output converters. Each clock it takes one 10-bit luma sample and two 10-bit colour-difference samples, together with a horizontal sync strobe, an active-video flag and a frame-start pulse. Control fields decide what reaches the output. The options are the incoming live pixels, a forced black picture, a cross-hatch test pattern, or a uniform field in a programmable colour.

The pattern colour comes from three 8-bit component values. Each value is widened to the 10-bit path by appending zero LSBs. The cross-hatch draws one-pixel-wide lines in that colour on black. A vertical line falls every 64 pixels and a horizontal line every 64 lines, both counted from the start of active video.

After selection, luma and chroma pass through independent delay lines. Each delay is programmable from 0 to 4 pixel clocks. Each is measured against the falling edge of the sync strobe that leaves the block.

Top module: `vid_pattern_delay`

## Requirements
- R1: When `pix_en_i` is 0 the block outputs black whatever the other controls say. Black is luma 64 and both colour components 512 on the 10-bit outputs.
- R2: When `pix_en_i` is 1 and `pat_en_i` is 0, the input samples reach the outputs unchanged.
- R3: When `pix_en_i`=1, `pat_en_i`=1 and `pat_field_i`=1, every active pixel takes the programmed colour and inactive pixels are black. The colour is `{col_x_i, 2'b00}` for each component.
- R4: When `pix_en_i`=1, `pat_en_i`=1 and `pat_field_i`=0, the output is a cross-hatch.
  - An active pixel takes the programmed colour when its column, counted from 0 at the first active pixel of the line, is a multiple of 64.
  - It also takes the colour when its line, counted from 0 at the first active line after `frame_i`, is a multiple of 64.
  - All other pixels are black.
- R5: `hsync_o` is `hsync_i` delayed by exactly one clock. Luma leaves `dly_y_i` further clocks after `hsync_o`, for codes 0 to 4.
- R6: Chroma (`cr_o`, `cb_o`) is delayed by `dly_c_i` clocks relative to `hsync_o`, independently of the luma delay and with the same encoding.
- R7: Delay codes 5, 6 and 7 act as a delay of 4 clocks on either path.
- R8: While `rst_n` is low, `y_o`, `cr_o`, `cb_o` and `hsync_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync strobe, active high |
| act_i | input | 1 | High during active video pixels |
| frame_i | input | 1 | One-cycle pulse before the first line of a frame |
| y_i | input | 10 | Luma sample |
| cr_i | input | 10 | Red colour-difference sample |
| cb_i | input | 10 | Blue colour-difference sample |
| pix_en_i | input | 1 | Pixel output enable; 0 forces black |
| pat_en_i | input | 1 | Test pattern enable |
| pat_field_i | input | 1 | Pattern kind: 0 hatch, 1 uniform field |
| col_y_i | input | 8 | Pattern colour, luma |
| col_cr_i | input | 8 | Pattern colour, red difference |
| col_cb_i | input | 8 | Pattern colour, blue difference |
| dly_y_i | input | 3 | Luma delay code |
| dly_c_i | input | 3 | Chroma delay code |
| y_o | output | 10 | Luma out |
| cr_o | output | 10 | Red difference out |
| cb_o | output | 10 | Blue difference out |
| hsync_o | output | 1 | Sync strobe aligned to zero delay |

## Verification
The hardest case to reach is the horizontal hatch line at line 64. It exists only after a frame pulse has cleared the line count and 64 further active lines have ended. The stimulus therefore drives a complete 70-line frame in hatch mode, with a frame pulse in the blanking before line 0. Delay changes are the second difficulty, because stale samples are still in the taps when a code changes. The scoreboard stamps every expected sample with the delay in force when it was driven, and compares an output only against entries whose stamp matches the current code. This lets several delay codes, including 5 and 7, be exercised back to back.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
   // Source chosen by the selection stage for one pixel
   typedef enum logic [1:0] {
      SRC_BLACK  = 2'd0,
      SRC_LIVE   = 2'd1,
      SRC_COLOUR = 2'd2
   } vpd_src_e;
endpackage

// File: rtl/vpd_hatch_gen.sv
module vpd_hatch_gen #(
   parameter int CNT_W = 12,
   parameter int PITCH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic frame_i,
   output logic on_line_o
);
   localparam logic [CNT_W-1:0] MASK = CNT_W'(PITCH - 1);

   if ((PITCH & (PITCH - 1)) != 0 || PITCH < 2) begin : g_bad_pitch
      $error("vpd_hatch_gen: PITCH must be a power of two >= 2");
   end
   if (PITCH > (1 << (CNT_W - 1))) begin : g_bad_cnt
      $error("vpd_hatch_gen: CNT_W too small for PITCH");
   end

   logic [CNT_W-1:0] px_q, ln_q;
   logic             act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         px_q  <= '0;
         ln_q  <= '0;
         act_q <= 1'b0;
      end else begin
         act_q <= act_i;
         px_q  <= act_i ? px_q + 1'b1 : '0;
         if (frame_i)
            ln_q <= '0;
         else if (act_q && !act_i)
            ln_q <= ln_q + 1'b1;
      end
   end

   assign on_line_o = act_i && (((px_q & MASK) == '0) || ((ln_q & MASK) == '0));
endmodule

// File: rtl/vpd_src_sel.sv
module vpd_src_sel
   import vpd_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int COL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en_i,
   input  logic              pat_en_i,
   input  logic              pat_field_i,
   input  logic              act_i,
   input  logic              on_line_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic [DATA_W-1:0] cr_i,
   input  logic [DATA_W-1:0] cb_i,
   input  logic [COL_W-1:0]  col_y_i,
   input  logic [COL_W-1:0]  col_cr_i,
   input  logic [COL_W-1:0]  col_cb_i,
   output logic [DATA_W-1:0]   y_q_o,
   output logic [2*DATA_W-1:0] c_q_o
);
   localparam int PAD = DATA_W - COL_W;
   localparam logic [DATA_W-1:0] BLK_Y = DATA_W'(16 << (DATA_W - 8));
   localparam logic [DATA_W-1:0] BLK_C = DATA_W'(128 << (DATA_W - 8));

   if (DATA_W < 8 || COL_W > DATA_W) begin : g_bad_w
      $error("vpd_src_sel: need DATA_W >= 8 and COL_W <= DATA_W");
   end

   logic [DATA_W-1:0] wy, wcr, wcb;

   if (PAD == 0) begin : g_col_direct
      assign wy  = col_y_i;
      assign wcr = col_cr_i;
      assign wcb = col_cb_i;
   end else begin : g_col_pad
      assign wy  = {col_y_i,  {PAD{1'b0}}};
      assign wcr = {col_cr_i, {PAD{1'b0}}};
      assign wcb = {col_cb_i, {PAD{1'b0}}};
   end

   vpd_src_e src;
   always_comb begin
      if (!pix_en_i)                      src = SRC_BLACK;
      else if (!pat_en_i)                 src = SRC_LIVE;
      else if (!act_i)                    src = SRC_BLACK;
      else if (pat_field_i || on_line_i)  src = SRC_COLOUR;
      else                                src = SRC_BLACK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q_o <= '0;
         c_q_o <= '0;
      end else begin
         unique case (src)
            SRC_LIVE: begin
               y_q_o <= y_i;
               c_q_o <= {cr_i, cb_i};
            end
            SRC_COLOUR: begin
               y_q_o <= wy;
               c_q_o <= {wcr, wcb};
            end
            default: begin
               y_q_o <= BLK_Y;
               c_q_o <= {BLK_C, BLK_C};
            end
         endcase
      end
   end
endmodule

// File: rtl/vpd_tap_line.sv
module vpd_tap_line #(
   parameter int W       = 10,
   parameter int DLY_W   = 3,
   parameter int MAX_DLY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     d_i,
   input  logic [DLY_W-1:0] code_i,
   output logic [W-1:0]     q_o
);
   localparam logic [DLY_W-1:0] LIM = DLY_W'(MAX_DLY);

   if (MAX_DLY < 1 || MAX_DLY >= (1 << DLY_W)) begin : g_bad_dly
      $error("vpd_tap_line: MAX_DLY must be 1 .. 2**DLY_W-1");
   end

   logic [W-1:0]     stg [1:MAX_DLY];
   logic [DLY_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 1; k <= MAX_DLY; k++) stg[k] <= '0;
      end else begin
         stg[1] <= d_i;
         for (int k = 2; k <= MAX_DLY; k++) stg[k] <= stg[k-1];
      end
   end

   assign sel = (code_i > LIM) ? LIM : code_i;

   always_comb begin
      if (sel == '0) q_o = d_i;
      else           q_o = stg[sel];
   end
endmodule

// File: rtl/vid_pattern_delay.sv
module vid_pattern_delay #(
   parameter int DATA_W  = 10,
   parameter int COL_W   = 8,
   parameter int DLY_W   = 3,
   parameter int MAX_DLY = 4,
   parameter int PITCH   = 64,
   parameter int CNT_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_i,
   input  logic              act_i,
   input  logic              frame_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic [DATA_W-1:0] cr_i,
   input  logic [DATA_W-1:0] cb_i,
   input  logic              pix_en_i,
   input  logic              pat_en_i,
   input  logic              pat_field_i,
   input  logic [COL_W-1:0]  col_y_i,
   input  logic [COL_W-1:0]  col_cr_i,
   input  logic [COL_W-1:0]  col_cb_i,
   input  logic [DLY_W-1:0]  dly_y_i,
   input  logic [DLY_W-1:0]  dly_c_i,
   output logic [DATA_W-1:0] y_o,
   output logic [DATA_W-1:0] cr_o,
   output logic [DATA_W-1:0] cb_o,
   output logic              hsync_o
);
   localparam int CW = 2 * DATA_W;

   logic              on_line;
   logic [DATA_W-1:0] y_sel;
   logic [CW-1:0]     c_sel, c_out;
   logic              hs_q;

   vpd_hatch_gen #(.CNT_W(CNT_W), .PITCH(PITCH)) u_hatch (
      .clk(clk), .rst_n(rst_n), .act_i(act_i), .frame_i(frame_i),
      .on_line_o(on_line)
   );

   vpd_src_sel #(.DATA_W(DATA_W), .COL_W(COL_W)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .pix_en_i(pix_en_i), .pat_en_i(pat_en_i), .pat_field_i(pat_field_i),
      .act_i(act_i), .on_line_i(on_line),
      .y_i(y_i), .cr_i(cr_i), .cb_i(cb_i),
      .col_y_i(col_y_i), .col_cr_i(col_cr_i), .col_cb_i(col_cb_i),
      .y_q_o(y_sel), .c_q_o(c_sel)
   );

   // Sync reference shares the single selection register stage
   always_ff @(posedge clk) begin
      if (!rst_n) hs_q <= 1'b0;
      else        hs_q <= hsync_i;
   end

   vpd_tap_line #(.W(DATA_W), .DLY_W(DLY_W), .MAX_DLY(MAX_DLY)) u_dly_y (
      .clk(clk), .rst_n(rst_n), .d_i(y_sel), .code_i(dly_y_i), .q_o(y_o)
   );

   vpd_tap_line #(.W(CW), .DLY_W(DLY_W), .MAX_DLY(MAX_DLY)) u_dly_c (
      .clk(clk), .rst_n(rst_n), .d_i(c_sel), .code_i(dly_c_i), .q_o(c_out)
   );

   assign cr_o    = c_out[CW-1:DATA_W];
   assign cb_o    = c_out[DATA_W-1:0];
   assign hsync_o = hs_q;
endmodule

// File: rtl/vpd_checker.sv
module vpd_checker #(
   parameter int DATA_W = 10,
   parameter int DLY_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hsync_i,
   input logic              pix_en_i,
   input logic              pat_en_i,
   input logic [DATA_W-1:0] y_i,
   input logic [DATA_W-1:0] cr_i,
   input logic [DLY_W-1:0]  dly_y_i,
   input logic [DLY_W-1:0]  dly_c_i,
   input logic [DATA_W-1:0] y_o,
   input logic [DATA_W-1:0] cr_o,
   input logic [DATA_W-1:0] cb_o,
   input logic              hsync_o
);
   localparam logic [DATA_W-1:0] BLK_Y = DATA_W'(16 << (DATA_W - 8));
   localparam logic [DATA_W-1:0] BLK_C = DATA_W'(128 << (DATA_W - 8));

   // Clocks since reset released, saturating; guards $past windows
   logic [2:0] warm_q;
   always_ff @(posedge clk) begin
      if (!rst_n)              warm_q <= '0;
      else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
   end

   // R8: outputs cleared while reset held (checked after the reset edge)
   p_reset_zero_r8: assert property (@(posedge clk)
      !rst_n |=> (!rst_n -> (y_o == '0 && cr_o == '0 && cb_o == '0 && !hsync_o)));

   p_black_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_en_i && dly_y_i == '0 && dly_c_i == '0) |=>
      (dly_y_i != '0 || dly_c_i != '0 ||
       (y_o == BLK_Y && cr_o == BLK_C && cb_o == BLK_C)));

   p_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en_i && !pat_en_i && dly_y_i == '0) |=>
      (dly_y_i != '0 || y_o == $past(y_i)));

   p_hsync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> hsync_o == $past(hsync_i));

   p_luma_dly2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 3'd3 && dly_y_i == DLY_W'(2) && $past(pix_en_i && !pat_en_i, 3))
      |-> y_o == $past(y_i, 3));

   p_chroma_dly_big_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 3'd5 && dly_c_i >= DLY_W'(5) && $past(pix_en_i && !pat_en_i, 5))
      |-> cr_o == $past(cr_i, 5));
endmodule

bind vid_pattern_delay vpd_checker #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_vpd_chk (
   .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i),
   .pix_en_i(pix_en_i), .pat_en_i(pat_en_i),
   .y_i(y_i), .cr_i(cr_i), .dly_y_i(dly_y_i), .dly_c_i(dly_c_i),
   .y_o(y_o), .cr_o(cr_o), .cb_o(cb_o), .hsync_o(hsync_o)
);

// File: tb/vid_pattern_delay_tb_top.sv
module vid_pattern_delay_tb_top;
   localparam int DEPTH = 16384;
   localparam int H_TOT = 160;
   localparam int A0    = 16;
   localparam int A_W   = 140;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       hsync_i = 1'b0, act_i = 1'b0, frame_i = 1'b0;
   logic [9:0] y_i = '0, cr_i = '0, cb_i = '0;
   logic       pix_en_i = 1'b0, pat_en_i = 1'b0, pat_field_i = 1'b0;
   logic [7:0] col_y_i = 8'd235, col_cr_i = 8'd128, col_cb_i = 8'd128;
   logic [2:0] dly_y_i = '0, dly_c_i = '0;
   logic [9:0] y_o, cr_o, cb_o;
   logic       hsync_o;

   vid_pattern_delay dut_i (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .act_i(act_i), .frame_i(frame_i),
      .y_i(y_i), .cr_i(cr_i), .cb_i(cb_i),
      .pix_en_i(pix_en_i), .pat_en_i(pat_en_i), .pat_field_i(pat_field_i),
      .col_y_i(col_y_i), .col_cr_i(col_cr_i), .col_cb_i(col_cb_i),
      .dly_y_i(dly_y_i), .dly_c_i(dly_c_i),
      .y_o(y_o), .cr_o(cr_o), .cb_o(cb_o), .hsync_o(hsync_o)
   );

   int errors = 0, checks = 0, cyc = 0;
   bit run = 1'b0, done = 1'b0;

   // Scoreboard: expected items indexed by the clock edge that captures them
   logic [9:0] ey [DEPTH];
   logic [9:0] ecr[DEPTH];
   logic [9:0] ecb[DEPTH];
   bit         ehs[DEPTH];
   bit         vld[DEPTH];
   int         sy [DEPTH];
   int         sc [DEPTH];
   string      etag[DEPTH];

   function automatic int eff(logic [2:0] c);
      return (c > 3'd4) ? 4 : int'(c);   // R7 clamp
   endfunction

   task automatic chk(string tag, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", tag, what, got, exp, cyc);
      end
   endtask

   // Monitor: compares outputs after each edge against the stamped entries
   always @(posedge clk) begin
      int ny, nc, iy, ic;
      #2;
      if (run && cyc < DEPTH) begin
         ny = eff(dly_y_i);
         nc = eff(dly_c_i);
         iy = cyc - ny;
         ic = cyc - nc;
         if (iy >= 0 && vld[iy] && sy[iy] == ny)
            chk(etag[iy], "luma", int'(y_o), int'(ey[iy]));
         if (ic >= 0 && vld[ic] && sc[ic] == nc) begin
            chk(etag[ic], "cr", int'(cr_o), int'(ecr[ic]));
            chk(etag[ic], "cb", int'(cb_o), int'(ecb[ic]));
         end
         if (vld[cyc]) chk("R5", "hsync_o", int'(hsync_o), int'(ehs[cyc]));
      end
      cyc++;
   end

   function automatic string mk_tag();
      string m;
      if (!pix_en_i)        m = "R1";
      else if (!pat_en_i)   m = "R2";
      else if (pat_field_i) m = "R3";
      else                  m = "R4";
      m = {m, $sformatf(" R5 y=%0d R6 c=%0d", dly_y_i, dly_c_i)};
      if (dly_y_i > 3'd4 || dly_c_i > 3'd4) m = {m, " R7"};
      return m;
   endfunction

   // Driver: one pixel per call, records the undelayed expectation
   task automatic drive_px(int col, int line, bit new_frame);
      logic [9:0] xy, xcr, xcb;
      bit a, on;
      @(negedge clk);
      a       = (col >= A0) && (col < A0 + A_W);
      hsync_i = (col < 4);
      act_i   = a;
      frame_i = new_frame && (line == 0) && (col == 1);
      y_i     = 10'($urandom);
      cr_i    = 10'($urandom);
      cb_i    = 10'($urandom);
      on = a && ((((col - A0) % 64) == 0) || ((line % 64) == 0));
      if (!pix_en_i) begin
         xy = 10'd64; xcr = 10'd512; xcb = 10'd512;
      end else if (!pat_en_i) begin
         xy = y_i; xcr = cr_i; xcb = cb_i;
      end else if (a && (pat_field_i || on)) begin
         xy = {col_y_i, 2'b00}; xcr = {col_cr_i, 2'b00}; xcb = {col_cb_i, 2'b00};
      end else begin
         xy = 10'd64; xcr = 10'd512; xcb = 10'd512;
      end
      if (cyc < DEPTH) begin
         ey[cyc] = xy; ecr[cyc] = xcr; ecb[cyc] = xcb;
         ehs[cyc] = hsync_i; sy[cyc] = eff(dly_y_i); sc[cyc] = eff(dly_c_i);
         etag[cyc] = mk_tag(); vld[cyc] = 1'b1;
      end
   endtask

   task automatic run_lines(int n, bit new_frame);
      for (int l = 0; l < n; l++)
         for (int c = 0; c < H_TOT; c++)
            drive_px(c, l, new_frame);
   endtask

   task automatic set_ctl(bit pe, bit te, bit fld, logic [2:0] dy, logic [2:0] dc);
      @(negedge clk);
      pix_en_i = pe; pat_en_i = te; pat_field_i = fld;
      dly_y_i = dy; dly_c_i = dc;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) vld[i] = 1'b0;
      // R8: reset state with live-looking stimulus present
      pix_en_i = 1'b1; y_i = 10'h3FF; hsync_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8", "y_o in reset", int'(y_o), 0);
      chk("R8", "cr_o in reset", int'(cr_o), 0);
      chk("R8", "cb_o in reset", int'(cb_o), 0);
      chk("R8", "hsync_o in reset", int'(hsync_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      run = 1'b1;

      // R2 live pass-through, no delay
      set_ctl(1, 0, 0, 3'd0, 3'd0);
      run_lines(2, 0);
      // R5/R6 independent delays on live data
      set_ctl(1, 0, 0, 3'd2, 3'd4);
      run_lines(2, 0);
      // R1 black overrides an enabled pattern
      set_ctl(0, 1, 1, 3'd0, 3'd0);
      run_lines(1, 0);
      // R3 uniform red field, luma 3 and chroma 1 clocks
      col_y_i = 8'd81; col_cr_i = 8'd240; col_cb_i = 8'd90;
      set_ctl(1, 1, 1, 3'd3, 3'd1);
      run_lines(2, 0);
      // R4 full hatch frame in white, R7 codes 7 and 5
      col_y_i = 8'd235; col_cr_i = 8'd128; col_cb_i = 8'd128;
      set_ctl(1, 1, 0, 3'd7, 3'd5);
      run_lines(70, 1);
      // R7 code 6 on luma, R6 code 4 on chroma, live data
      set_ctl(1, 0, 0, 3'd6, 3'd4);
      run_lines(2, 0);
      repeat (8) @(negedge clk);
      run = 1'b0;
      finish_run();
   end
endmodule